// File: doc/BRIEF.md
# Sixteen-Function ALU with Flags

A purely combinational 32-bit arithmetic/logic unit that evaluates one of sixteen fixed operations on two source operands. It returns the result word together with five condition flags: overflow, negative, zero, carry and all-ones. The operation set mixes the usual add, subtract and bitwise operations with less common ones: the first operand plus the bitwise AND of both operands, the complement of the first operand ANDed or ORed with the second, doubling, decrement and a constant one.

The opcode, the use-carry control bit and the current carry flag come from the surrounding decode and status logic. When the use-carry control bit is set, the arithmetic operations take the incoming carry flag as an extra addend, so that wide values can be added or subtracted across several words. The flags are always produced. The status register outside this block decides whether to latch them.

Top module: `sixteen_op_alu`

## Requirements
- R1: With use_carry_i low, the arithmetic opcodes give results modulo 2^32: 0001 gives src0-src1, 0010 gives src0+(src0&src1), 0011 gives src0+src1, 0100 gives 2*src0 and 0101 gives src0-1.
- R2: The pass and logic opcodes give: 0000 src0, 0110 ~src0, 0111 ~(src0|src1), 1000 ~src0&src1, 1001 ~(src0&src1), 1010 src0^src1, 1011 ~src0|src1, 1100 ~(src0^src1), 1101 src0&src1 and 1111 src0|src1.
- R3: Opcode 1110 gives the constant 0x00000001.
- R4: With use_carry_i high, the arithmetic opcodes add carry_i as an extra addend. For subtraction carry_i takes the place of the constant 1 in src0+~src1+1, so carry_i=0 yields src0-src1-1.
- R5: For opcodes 0000, 0110 to 1111, use_carry_i and carry_i have no effect on the result or on any flag.
- R6: For arithmetic opcodes, flag_c_o is the carry out of bit 31 of the internal sum. For subtraction it is therefore 1 exactly when no borrow occurs.
- R7: For arithmetic opcodes, flag_v_o is 1 exactly when the signed value of the full sum (both addends plus carry-in) lies outside the 32-bit two's-complement range.
- R8: For pass, logic and constant opcodes, flag_c_o and flag_v_o are 0.
- R9: For every opcode, flag_n_o equals result bit 31, flag_z_o is 1 exactly when the result is 0, and flag_x_o is 1 exactly when the result is 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src0_i | input | 32 | First source operand |
| src1_i | input | 32 | Second source operand |
| opcode_i | input | 4 | Operation select |
| use_carry_i | input | 1 | Add carry_i into arithmetic operations |
| carry_i | input | 1 | Current carry flag from the status register |
| result_o | output | 32 | Operation result |
| flag_v_o | output | 1 | Signed overflow |
| flag_n_o | output | 1 | Result negative |
| flag_z_o | output | 1 | Result zero |
| flag_c_o | output | 1 | Carry out / no borrow |
| flag_x_o | output | 1 | Result is all ones |

## Verification
Carry-in injection and flag generation meet in the same evaluation whenever the extra addend alone pushes a sum across a boundary. Examples are 0x7FFFFFFF plus zero with carry set, which must raise overflow and negative together, and 0xFFFFFFFF plus zero with carry set, which must raise carry and zero together. The bench provokes these by sweeping every opcode over all pairs of the boundary operands 0, 1, -1, 0x7FFFFFFF and 0x80000000 with every combination of use-carry and carry. It judges the result and each flag separately against a model that works in exact 64-bit signed and unsigned arithmetic.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_MOVE = 4'h0,
    OP_SUB  = 4'h1,
    OP_MDBL = 4'h2,
    OP_ADD  = 4'h3,
    OP_DBL  = 4'h4,
    OP_DEC  = 4'h5,
    OP_NOT  = 4'h6,
    OP_NOR  = 4'h7,
    OP_IAND = 4'h8,
    OP_NAND = 4'h9,
    OP_XOR  = 4'hA,
    OP_IOR  = 4'hB,
    OP_XNOR = 4'hC,
    OP_AND  = 4'hD,
    OP_ONE  = 4'hE,
    OP_OR   = 4'hF
  } alu_op_e;

  typedef struct packed {
    logic v;
    logic n;
    logic z;
    logic c;
    logic x;
  } alu_flags_t;

  function automatic logic op_is_arith(alu_op_e op);
    return (op == OP_SUB) || (op == OP_MDBL) || (op == OP_ADD) ||
           (op == OP_DBL) || (op == OP_DEC);
  endfunction

endpackage

// File: rtl/alu_addend_sel.sv
module alu_addend_sel
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] src0_i,
  input  logic [WIDTH-1:0] src1_i,
  input  logic             use_carry_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] add_a_o,
  output logic [WIDTH-1:0] add_b_o,
  output logic             add_cin_o,
  output logic             arith_o
);

  logic ext_c;
  assign ext_c   = use_carry_i & carry_i;
  assign add_a_o = src0_i;
  assign arith_o = op_is_arith(op_i);

  always_comb begin
    add_b_o   = '0;
    add_cin_o = 1'b0;
    unique case (op_i)
      OP_SUB: begin
        add_b_o   = ~src1_i;
        add_cin_o = use_carry_i ? carry_i : 1'b1;  // carry replaces the +1
      end
      OP_MDBL: begin
        add_b_o   = src0_i & src1_i;
        add_cin_o = ext_c;
      end
      OP_ADD: begin
        add_b_o   = src1_i;
        add_cin_o = ext_c;
      end
      OP_DBL: begin
        add_b_o   = src0_i;
        add_cin_o = ext_c;
      end
      OP_DEC: begin
        add_b_o   = '1;
        add_cin_o = ext_c;
      end
      default: begin
        add_b_o   = '0;
        add_cin_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int WIDTH  = 32,
  parameter bit RIPPLE = 1'b0
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  if (RIPPLE) begin : g_ripple
    logic [WIDTH:0] carry;
    assign carry[0] = cin_i;
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign sum_o[i]   = a_i[i] ^ b_i[i] ^ carry[i];
      assign carry[i+1] = (a_i[i] & b_i[i]) | (carry[i] & (a_i[i] ^ b_i[i]));
    end
    assign cout_o = carry[WIDTH];
  end else begin : g_infer
    logic [WIDTH:0] full;
    assign full   = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
    assign sum_o  = full[WIDTH-1:0];
    assign cout_o = full[WIDTH];
  end

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] src0_i,
  input  logic [WIDTH-1:0] src1_i,
  output logic [WIDTH-1:0] res_o
);

  localparam logic [WIDTH-1:0] ONE_VAL = WIDTH'(1);

  always_comb begin
    unique case (op_i)
      OP_MOVE: res_o = src0_i;
      OP_NOT:  res_o = ~src0_i;
      OP_NOR:  res_o = ~(src0_i | src1_i);
      OP_IAND: res_o = ~src0_i & src1_i;
      OP_NAND: res_o = ~(src0_i & src1_i);
      OP_XOR:  res_o = src0_i ^ src1_i;
      OP_IOR:  res_o = ~src0_i | src1_i;
      OP_XNOR: res_o = ~(src0_i ^ src1_i);
      OP_AND:  res_o = src0_i & src1_i;
      OP_ONE:  res_o = ONE_VAL;
      OP_OR:   res_o = src0_i | src1_i;
      default: res_o = '0;  // arithmetic group handled by the adder
    endcase
  end

endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] res_i,
  input  logic             arith_i,
  input  logic             cout_i,
  input  logic             a_msb_i,
  input  logic             b_msb_i,
  output alu_flags_t       flags_o
);

  localparam int MSB = WIDTH - 1;

  always_comb begin
    flags_o.n = res_i[MSB];
    flags_o.z = ~|res_i;
    flags_o.x = &res_i;
    flags_o.c = arith_i & cout_i;
    // same-sign addends with a sign change in the sum
    flags_o.v = arith_i & (a_msb_i ~^ b_msb_i) & (res_i[MSB] ^ a_msb_i);
  end

endmodule

// File: rtl/sixteen_op_alu.sv
module sixteen_op_alu
  import alu_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter bit RIPPLE = 1'b0
) (
  input  logic [WIDTH-1:0] src0_i,
  input  logic [WIDTH-1:0] src1_i,
  input  logic [3:0]       opcode_i,
  input  logic             use_carry_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] result_o,
  output logic             flag_v_o,
  output logic             flag_n_o,
  output logic             flag_z_o,
  output logic             flag_c_o,
  output logic             flag_x_o
);

  localparam int MSB = WIDTH - 1;

  alu_op_e          op;
  logic [WIDTH-1:0] add_a, add_b, sum, logic_res;
  logic             add_cin, cout, arith;
  alu_flags_t       flags;

  assign op = alu_op_e'(opcode_i);

  alu_addend_sel #(.WIDTH(WIDTH)) u_sel (
    .op_i        (op),
    .src0_i      (src0_i),
    .src1_i      (src1_i),
    .use_carry_i (use_carry_i),
    .carry_i     (carry_i),
    .add_a_o     (add_a),
    .add_b_o     (add_b),
    .add_cin_o   (add_cin),
    .arith_o     (arith)
  );

  alu_adder #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_add (
    .a_i    (add_a),
    .b_i    (add_b),
    .cin_i  (add_cin),
    .sum_o  (sum),
    .cout_o (cout)
  );

  alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .op_i   (op),
    .src0_i (src0_i),
    .src1_i (src1_i),
    .res_o  (logic_res)
  );

  assign result_o = arith ? sum : logic_res;

  alu_flag_gen #(.WIDTH(WIDTH)) u_flags (
    .res_i   (result_o),
    .arith_i (arith),
    .cout_i  (cout),
    .a_msb_i (add_a[MSB]),
    .b_msb_i (add_b[MSB]),
    .flags_o (flags)
  );

  assign flag_v_o = flags.v;
  assign flag_n_o = flags.n;
  assign flag_z_o = flags.z;
  assign flag_c_o = flags.c;
  assign flag_x_o = flags.x;

endmodule

// File: rtl/sixteen_op_alu_chk.sv
module sixteen_op_alu_chk
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] src0_i,
  input logic [3:0]       opcode_i,
  input logic [WIDTH-1:0] result_o,
  input logic             flag_v_o,
  input logic             flag_n_o,
  input logic             flag_z_o,
  input logic             flag_c_o,
  input logic             flag_x_o
);

  localparam int MSB = WIDTH - 1;

  alu_op_e op;
  assign op = alu_op_e'(opcode_i);

  always_comb begin
    a_r9_zero_not_neg: assert (!(flag_z_o && flag_n_o));
    a_r9_zero_not_ones: assert (!(flag_z_o && flag_x_o));
    a_r9_ones_is_neg: assert (!flag_x_o || flag_n_o);
    a_r8_no_cv_logic: assert (op_is_arith(op) || (!flag_c_o && !flag_v_o));
    a_r3_one_const: assert (op != OP_ONE || result_o == WIDTH'(1));
    a_r2_move_pass: assert (op != OP_MOVE || result_o == src0_i);
    a_r7_v_sign_flip: assert (!flag_v_o || (result_o[MSB] != src0_i[MSB]));
  end

endmodule

bind sixteen_op_alu sixteen_op_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .src0_i   (src0_i),
  .opcode_i (opcode_i),
  .result_o (result_o),
  .flag_v_o (flag_v_o),
  .flag_n_o (flag_n_o),
  .flag_z_o (flag_z_o),
  .flag_c_o (flag_c_o),
  .flag_x_o (flag_x_o)
);

// File: tb/sixteen_op_alu_bench.sv
module sixteen_op_alu_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 50000;
  localparam int N_RANDOM   = 400;

  typedef struct {
    logic [31:0] res;
    logic        v, n, z, c, x;
    string       tag_res;
    string       tag_cv;
    logic [3:0]  op;
    logic [31:0] s0, s1;
    logic        uc, ci;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src0 = '0, src1 = '0;
  logic [3:0]  opcode = '0;
  logic        use_carry = 1'b0, carry = 1'b0;
  logic [31:0] result;
  logic        fv, fn, fz, fc, fx;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sixteen_op_alu u_sixteen_op_alu (
    .src0_i      (src0),
    .src1_i      (src1),
    .opcode_i    (opcode),
    .use_carry_i (use_carry),
    .carry_i     (carry),
    .result_o    (result),
    .flag_v_o    (fv),
    .flag_n_o    (fn),
    .flag_z_o    (fz),
    .flag_c_o    (fc),
    .flag_x_o    (fx)
  );

  function automatic bit is_arith(logic [3:0] op);
    return op inside {4'h1, 4'h2, 4'h3, 4'h4, 4'h5};
  endfunction

  function automatic exp_t model(logic [31:0] s0, logic [31:0] s1,
                                 logic [3:0] op, logic uc, logic ci);
    exp_t e;
    logic [63:0] ua, ub, usum;
    longint sa, sb, ssum, k, brw;
    e.v = 1'b0; e.c = 1'b0; e.res = '0;
    k = (uc && ci) ? 1 : 0;
    if (op == 4'h1) begin
      brw   = (uc && !ci) ? 1 : 0;
      e.res = s0 - s1 - 32'(brw);
      e.c   = ({32'b0, s0} >= ({32'b0, s1} + 64'(brw)));
      ssum  = longint'($signed(s0)) - longint'($signed(s1)) - brw;
      e.v   = (ssum > 64'sd2147483647) || (ssum < -64'sd2147483648);
    end else if (is_arith(op)) begin
      ua = {32'b0, s0};
      sa = longint'($signed(s0));
      case (op)
        4'h2:    begin ua = {32'b0, s0}; ub = {32'b0, s0 & s1}; end
        4'h3:    ub = {32'b0, s1};
        4'h4:    ub = {32'b0, s0};
        default: ub = 64'h0000_0000_FFFF_FFFF;
      endcase
      sb   = longint'($signed(ub[31:0]));
      usum = ua + ub + 64'(k);
      ssum = sa + sb + k;
      e.res = usum[31:0];
      e.c   = usum[32];
      e.v   = (ssum > 64'sd2147483647) || (ssum < -64'sd2147483648);
    end else begin
      case (op)
        4'h0: e.res = s0;
        4'h6: e.res = ~s0;
        4'h7: e.res = ~(s0 | s1);
        4'h8: e.res = ~s0 & s1;
        4'h9: e.res = ~(s0 & s1);
        4'hA: e.res = s0 ^ s1;
        4'hB: e.res = ~s0 | s1;
        4'hC: e.res = ~(s0 ^ s1);
        4'hD: e.res = s0 & s1;
        4'hE: e.res = 32'h0000_0001;
        default: e.res = s0 | s1;
      endcase
    end
    e.n = e.res[31];
    e.z = (e.res == 32'h0);
    e.x = (e.res == 32'hFFFF_FFFF);
    if (is_arith(op)) e.tag_res = uc ? "R4" : "R1";
    else if (op == 4'hE) e.tag_res = uc ? "R5" : "R3";
    else e.tag_res = uc ? "R5" : "R2";
    e.tag_cv = is_arith(op) ? "R6 R7" : "R8";
    e.op = op; e.s0 = s0; e.s1 = s1; e.uc = uc; e.ci = ci;
    return e;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act,
                       logic [31:0] exp, exp_t e);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s op=%h s0=%h s1=%h uc=%0b c=%0b actual=%h expected=%h",
               tag, what, e.op, e.s0, e.s1, e.uc, e.ci, act, exp);
    end
  endtask

  task automatic drive(logic [31:0] s0, logic [31:0] s1, logic [3:0] op,
                       logic uc, logic ci);
    @(posedge clk);
    #1;
    src0 = s0; src1 = s1; opcode = op; use_carry = uc; carry = ci;
    sb_q.push_back(model(s0, s1, op, uc, ci));
  endtask

  // monitor: sample half a period after the drive
  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(result == e.res, e.tag_res, "result", result, e.res, e);
      check(fc == e.c, is_arith(e.op) ? "R6" : "R8", "flag_c", 32'(fc), 32'(e.c), e);
      check(fv == e.v, is_arith(e.op) ? "R7" : "R8", "flag_v", 32'(fv), 32'(e.v), e);
      check({fn, fz, fx} == {e.n, e.z, e.x}, "R9", "flags_nzx",
            32'({fn, fz, fx}), 32'({e.n, e.z, e.x}), e);
    end
  end

  // R5: carry controls must leave non-arithmetic outputs untouched
  task automatic check_ignore(logic [31:0] s0, logic [31:0] s1, logic [3:0] op);
    logic [36:0] base;
    exp_t e;
    e = model(s0, s1, op, 1'b0, 1'b0);
    @(posedge clk); #1;
    src0 = s0; src1 = s1; opcode = op; use_carry = 1'b0; carry = 1'b0;
    @(negedge clk);
    base = {result, fv, fn, fz, fc, fx};
    @(posedge clk); #1;
    use_carry = 1'b1; carry = 1'b1;
    @(negedge clk);
    check({result, fv, fn, fz, fc, fx} == base, "R5", "carry_ignored",
          result, base[36:5], e);
  endtask

  localparam logic [31:0] BND [5] = '{32'h0, 32'h1, 32'hFFFF_FFFF,
                                      32'h7FFF_FFFF, 32'h8000_0000};

  initial begin
    exp_t e0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    e0 = model('0, '0, 4'h0, 1'b0, 1'b0);
    // reset state: idle inputs give a zero result with only Z set
    check(result == 32'h0, "R2", "reset_result", result, 32'h0, e0);
    check({fv, fn, fz, fc, fx} == 5'b00100, "R9", "reset_flags",
          32'({fv, fn, fz, fc, fx}), 32'h4, e0);

    for (int op = 0; op < 16; op++)
      for (int m = 0; m < 4; m++)
        for (int i = 0; i < 5; i++)
          for (int j = 0; j < 5; j++)
            drive(BND[i], BND[j], 4'(op), m[1], m[0]);

    for (int n = 0; n < N_RANDOM; n++)
      drive($urandom, $urandom, 4'($urandom_range(0, 15)),
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));

    wait (sb_q.size() == 0);
    @(negedge clk);

    for (int op = 0; op < 16; op++)
      if (!is_arith(4'(op))) check_ignore(32'hA5A5_0F0F, 32'h3C3C_F0F0, 4'(op));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired after %0d cycles", WD_CYCLES);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule